// File: doc/BRIEF.md
# Prescaled PWM Timer with Shadowed Settings

A single-channel pulse-width timer driven from one clock and set up through two 32-bit registers on a simple write/read bus. The control word enables the channel, holds a hold-update flag and selects a power-of-two prescale exponent. The count word holds a 10-bit period and a 10-bit high time, both counted in prescaled ticks. Each period starts with the output high. The output stays high for the high time and then low until the period ends.

New count and prescale settings are written into a pending copy. The pending copy moves into the working copy in one step. While the block is idle this happens at once. While it is running it happens only at the end of a whole period, and never while the hold flag is set. Software can therefore change the period, the high time and the prescaler together without a glitch. A zero period or a zero high time is a forbidden setting: the channel will not run on it, so a 0% duty output is never produced.

Top module: `pwm_shadow_timer`

## Requirements
- R1: After reset `pwm_out` is low and both registers read as 0.
- R2: Control word at address 0x0: bit 0 enable, bit 4 a stored source flag with no other effect, bit 11 hold, bit 15 prescale range, bits 19:16 prescale step. Count word at address 0x4: period in bits 25:16, high time in bits 9:0. Reads return the last written values, including pending ones. Unused bits and other addresses read 0.
- R3: The prescale exponent is d = {range, step} limited to 24. One tick lasts 2^d clocks. A running period lasts P·2^d clocks, with `pwm_out` high for the first H·2^d of them, and then repeats.
- R4: When H ≥ P the output stays high for the whole of every period.
- R5: While the working period or high time is zero the channel does not run and `pwm_out` stays low. Once valid values are written and the channel is enabled, output starts with a high phase.
- R6: While hold is 1, count and prescale writes do not take effect. After hold is cleared they take effect together.
- R7: A settings change written while running takes effect only at the next period boundary. The period in progress completes with the old values.
- R8: Writing enable = 0 forces `pwm_out` low from the clock edge that stores the write. A later enable restarts counting from zero, so the first period is a full one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the prescaler source |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pwm_out | output | 1 | Active-high pulse output |

## Verification
Several properties hold on every cycle and are checked that way. The counter stays inside the working period. The prescaler stays inside its window. The channel never runs on a zero setting. The output is high at the start of every period and stays high when the high time covers the period. A settings change while running lands only with the counter at zero. Hold freezes the working settings. A disabling write silences the output on the next cycle. Only the bench scenarios can show that measured pulse widths match P·2^d and H·2^d, that values written under hold show up as one combined change, that the period in progress keeps its old values, and that a re-enabled channel begins with a full period.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam int BUS_W   = 32;
  localparam int CNT_W   = 10;
  localparam int DIV_W   = 4;
  localparam int EXP_W   = DIV_W + 1;
  localparam int MAX_EXP = 24;

  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_COUNT = 4;

  localparam int CTRL_EN     = 0;
  localparam int CTRL_SRC    = 4;
  localparam int CTRL_SYNC   = 11;
  localparam int CTRL_MODE   = 15;
  localparam int CTRL_DIV_LO = 16;
  localparam int CNT_PER_LO  = 16;
  localparam int CNT_PH_LO   = 0;

  typedef struct packed {
    logic             mode;
    logic [DIV_W-1:0] div;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] phase;
  } pwmt_set_t;

  function automatic logic [EXP_W-1:0] pwmt_exp(input logic mode, input logic [DIV_W-1:0] div);
    logic [EXP_W-1:0] raw;
    raw = {mode, div};
    return (raw > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : raw;
  endfunction

  function automatic logic [MAX_EXP-1:0] pwmt_mask(input logic [EXP_W-1:0] e);
    logic [MAX_EXP-1:0] m;
    for (int i = 0; i < MAX_EXP; i++) m[i] = (i < int'(e));
    return m;
  endfunction

  function automatic logic pwmt_ok(input pwmt_set_t s);
    return (s.period != '0) && (s.phase != '0);
  endfunction

  function automatic logic pwmt_high(input logic [CNT_W-1:0] cnt, input logic [CNT_W-1:0] ph);
    return cnt < ph;
  endfunction
endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
  import pwmt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              run_q,
  input  logic              boundary,
  output logic              en_q,
  output logic              sync_q,
  output pwmt_set_t         act_q,
  output logic              pend_ok,
  output logic              commit
);
  logic      src_q;
  logic      dirty_q;
  pwmt_set_t pend_q;
  logic      wr_ctrl;
  logic      wr_count;
  logic      unused_wdata;

  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
  assign wr_count = bus_wr && (bus_addr == ADDR_W'(ADDR_COUNT));
  assign commit   = dirty_q && !sync_q && (!run_q || boundary);
  assign pend_ok  = pwmt_ok(pend_q);
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      src_q   <= 1'b0;
      sync_q  <= 1'b0;
      dirty_q <= 1'b0;
      pend_q  <= '0;
      act_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q        <= bus_wdata[CTRL_EN];
        src_q       <= bus_wdata[CTRL_SRC];
        sync_q      <= bus_wdata[CTRL_SYNC];
        pend_q.mode <= bus_wdata[CTRL_MODE];
        pend_q.div  <= bus_wdata[CTRL_DIV_LO +: DIV_W];
      end
      if (wr_count) begin
        pend_q.period <= bus_wdata[CNT_PER_LO +: CNT_W];
        pend_q.phase  <= bus_wdata[CNT_PH_LO +: CNT_W];
      end
      if (wr_ctrl || wr_count) dirty_q <= 1'b1;
      else if (commit)         dirty_q <= 1'b0;
      if (commit) act_q <= pend_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(ADDR_CTRL)) begin
      bus_rdata[CTRL_EN]                 = en_q;
      bus_rdata[CTRL_SRC]                = src_q;
      bus_rdata[CTRL_SYNC]               = sync_q;
      bus_rdata[CTRL_MODE]               = pend_q.mode;
      bus_rdata[CTRL_DIV_LO +: DIV_W]    = pend_q.div;
    end else if (bus_addr == ADDR_W'(ADDR_COUNT)) begin
      bus_rdata[CNT_PER_LO +: CNT_W]     = pend_q.period;
      bus_rdata[CNT_PH_LO +: CNT_W]      = pend_q.phase;
    end
  end

  // R6: hold flag freezes the working settings
  a_r6_sync_holds: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |=> $stable(act_q));
endmodule

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler
  import pwmt_pkg::*;
#(
  parameter int PRE_W = MAX_EXP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_q,
  input  logic [EXP_W-1:0] exp_act,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt_q;
  logic [PRE_W-1:0] mask;

  assign mask = PRE_W'(pwmt_mask(exp_act));
  assign tick = run_q && ((pcnt_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)             pcnt_q <= '0;
    else if (!run_q || tick) pcnt_q <= '0;
    else                     pcnt_q <= pcnt_q + PRE_W'(1);
  end

  // R3: prescaler never leaves the window of the working exponent
  a_r3_pre_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> ((pcnt_q & ~mask) == '0));
  // R8: an idle channel clears the prescaler
  a_r8_pre_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (pcnt_q == '0));
endmodule

// File: rtl/pwmt_phase_ctr.sv
module pwmt_phase_ctr
  import pwmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_q,
  input  logic             tick,
  input  logic             commit,
  input  logic             pend_ok,
  input  pwmt_set_t        act_q,
  output logic             run_q,
  output logic             boundary,
  output logic [CNT_W-1:0] cnt_q,
  output logic             pwm_out
);
  logic act_ok;
  logic run_d;

  assign act_ok   = pwmt_ok(act_q);
  assign run_d    = en_q && (commit ? pend_ok : act_ok);
  assign boundary = run_q && tick && (cnt_q == act_q.period - CNT_W'(1));
  assign pwm_out  = en_q && run_q && pwmt_high(cnt_q, act_q.phase);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      if (!run_q)        cnt_q <= '0;
      else if (boundary) cnt_q <= '0;
      else if (tick)     cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R3: counter stays below the working period
  a_r3_cnt_below_period: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < act_q.period));
  // R5: never running on a forbidden setting
  a_r5_run_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> ((act_q.period != '0) && (act_q.phase != '0)));
  // R5: each period opens high, so no 0% duty
  a_r5_high_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && run_q && (cnt_q == '0)) |-> pwm_out);
  // R8: idle clears the counter
  a_r8_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_shadow_timer.sv
module pwm_shadow_timer
  import pwmt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              pwm_out
);
  logic             en_q;
  logic             sync_q;
  pwmt_set_t        act_q;
  logic             pend_ok;
  logic             commit;
  logic             run_q;
  logic             boundary;
  logic             tick;
  logic [CNT_W-1:0] cnt_q;
  logic [EXP_W-1:0] exp_act;

  assign exp_act = pwmt_exp(act_q.mode, act_q.div);

  pwmt_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .run_q(run_q),
    .boundary(boundary), .en_q(en_q), .sync_q(sync_q), .act_q(act_q),
    .pend_ok(pend_ok), .commit(commit)
  );

  pwmt_prescaler #(.PRE_W(MAX_EXP)) i_pre (
    .clk(clk), .rst_n(rst_n), .run_q(run_q), .exp_act(exp_act), .tick(tick)
  );

  pwmt_phase_ctr i_ctr (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .tick(tick), .commit(commit),
    .pend_ok(pend_ok), .act_q(act_q), .run_q(run_q), .boundary(boundary),
    .cnt_q(cnt_q), .pwm_out(pwm_out)
  );

  // R7: a change of working settings while running lands at count zero
  a_r7_change_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && (act_q != $past(act_q))) |-> (cnt_q == '0));
  // R4: high time covering the period keeps the output high
  a_r4_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && run_q && (act_q.phase >= act_q.period)) |-> pwm_out);
  // R8: a disabling write silences the output on the next cycle
  a_r8_write_off: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL)) && !bus_wdata[CTRL_EN]) |=> !pwm_out);
endmodule

// File: tb/test_pwm_shadow_timer.sv
module test_pwm_shadow_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;
  int q_hi[$];
  int q_lo[$];
  string q_req[$];

  always #5 clk = ~clk;

  pwm_shadow_timer #(.ADDR_W(4)) i_pwm_shadow_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_w(input bit en, input bit sync, input int div);
    return (32'(en) << 0) | (32'(sync) << 11) | (32'(div & 15) << 16);
  endfunction

  function automatic logic [31:0] cnt_w(input int per, input int ph);
    return (32'(per & 1023) << 16) | 32'(ph & 1023);
  endfunction

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read_check(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, "register read", int'(bus_rdata), int'(exp));
  endtask

  task automatic push(input int hi, input int lo, input string req, input int n);
    for (int i = 0; i < n; i++) begin
      q_hi.push_back(hi); q_lo.push_back(lo); q_req.push_back(req);
    end
  endtask

  task automatic drain();
    while (q_hi.size() != 0) @(negedge clk);
  endtask

  task automatic count_level(input int n, input bit lvl, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out == lvl) hits++;
    end
  endtask

  // monitor: measures each high/low pair and compares with the scoreboard
  int  m_state = 0;
  int  m_hi = 0;
  int  m_lo = 0;
  bit  m_prev = 1'b0;
  always @(negedge clk) begin
    if (!mon_en) begin
      m_state = 0; m_hi = 0; m_lo = 0; m_prev = pwm_out;
    end else begin
      case (m_state)
        0: if (pwm_out && !m_prev) begin m_state = 1; m_hi = 1; m_lo = 0; end
        1: if (pwm_out) m_hi++; else begin m_state = 2; m_lo = 1; end
        default: if (!pwm_out) m_lo++;
                 else begin
                   if (q_hi.size() != 0) begin
                     string r;
                     int eh, el;
                     eh = q_hi.pop_front(); el = q_lo.pop_front(); r = q_req.pop_front();
                     check(r, "high cycles", m_hi, eh);
                     check(r, "low cycles", m_lo, el);
                   end
                   m_state = 1; m_hi = 1; m_lo = 0;
                 end
      endcase
      m_prev = pwm_out;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int hits;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "pwm_out after reset", int'(pwm_out), 0);
    bus_read_check(4'h0, 32'h0, "R1");
    bus_read_check(4'h4, 32'h0, "R1");

    // R2 map and readback of pending fields
    bus_write(4'h0, 32'hFFFF_FFFE);
    bus_read_check(4'h0, 32'h000F_8810, "R2");
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_read_check(4'h4, 32'h03FF_03FF, "R2");
    bus_read_check(4'h8, 32'h0, "R2");
    bus_write(4'h0, 32'h0);

    // R3 divide by 1: P=10 H=3
    bus_write(4'h4, cnt_w(10, 3));
    mon_en = 1'b1;
    push(3, 7, "R3", 3);
    bus_write(4'h0, ctrl_w(1, 0, 0));
    drain();

    // R7 change while running lands at next boundary
    push(3, 7, "R7", 1);
    push(2, 4, "R7", 2);
    bus_write(4'h4, cnt_w(6, 2));
    drain();

    // R6 hold: stage P=5 H=3 with div 1 together
    push(2, 4, "R6", 1);
    drain();
    bus_write(4'h0, ctrl_w(1, 1, 1));
    bus_write(4'h4, cnt_w(5, 3));
    bus_read_check(4'h4, 32'h0005_0003, "R6");
    push(2, 4, "R6", 2);
    drain();
    push(2, 4, "R6", 1);
    push(6, 4, "R6", 2);
    bus_write(4'h0, ctrl_w(1, 0, 1));
    drain();

    // R8 immediate stop and restart from zero
    mon_en = 1'b0;
    bus_write(4'h0, ctrl_w(0, 0, 1));
    check("R8", "pwm_out after disable write", int'(pwm_out), 0);
    count_level(20, 1'b1, hits);
    check("R8", "high samples while disabled", hits, 0);
    mon_en = 1'b1;
    @(negedge clk);
    push(6, 4, "R8", 2);
    bus_write(4'h0, ctrl_w(1, 0, 1));
    drain();

    // R3 divide by 4: P=5 H=2
    mon_en = 1'b0;
    bus_write(4'h0, ctrl_w(0, 0, 2));
    bus_write(4'h4, cnt_w(5, 2));
    mon_en = 1'b1;
    @(negedge clk);
    push(8, 12, "R3", 2);
    bus_write(4'h0, ctrl_w(1, 0, 2));
    drain();

    // R4 high time equal to and above the period
    mon_en = 1'b0;
    bus_write(4'h0, ctrl_w(0, 0, 0));
    bus_write(4'h4, cnt_w(4, 4));
    bus_write(4'h0, ctrl_w(1, 0, 0));
    repeat (2) @(negedge clk);
    count_level(40, 1'b0, hits);
    check("R4", "low samples with H=P", hits, 0);
    bus_write(4'h4, cnt_w(4, 9));
    repeat (8) @(negedge clk);
    count_level(40, 1'b0, hits);
    check("R4", "low samples with H>P", hits, 0);

    // R5 forbidden settings keep output low, then valid values start high
    bus_write(4'h0, ctrl_w(0, 0, 0));
    bus_write(4'h4, cnt_w(0, 5));
    bus_write(4'h0, ctrl_w(1, 0, 0));
    count_level(50, 1'b1, hits);
    check("R5", "high samples with zero period", hits, 0);
    bus_write(4'h4, cnt_w(6, 0));
    count_level(50, 1'b1, hits);
    check("R5", "high samples with zero high time", hits, 0);
    mon_en = 1'b1;
    @(negedge clk);
    push(2, 4, "R5", 2);
    bus_write(4'h4, cnt_w(6, 2));
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule